// File: doc/BRIEF.md
# Timer DMA burst register sequencer

The sequencer sits between one DMA access window and a timer's register file. Software programs a base register slot and a transfer count into a small configuration register. Each time the timer signals an update, and update-driven DMA is enabled, the block asks the DMA controller for service. It then steers every access the controller makes through the window onto the register at base plus a running index. Several consecutive timer registers are refreshed per update from one linear memory buffer.

The index starts at zero on every new request, climbs by one per acknowledged access and wraps after the last transfer of the burst. The request is withdrawn once the last transfer is acknowledged. Register slots marked reserved absorb writes silently and read as zero. The block also produces the counter run enable used while the processor is halted by a debugger.

Top module: `burst_seq`

## Requirements
- R1: `dma_req_o` rises in the cycle after an `update_i` pulse only while `upd_dma_en_i` is 1; with the enable at 0 an update leaves the request low.
- R2: During an access, `reg_addr_o` is the byte address 4 × (base + index), where base is the stored base slot and index starts at 0, so the first access of a burst lands on the base slot.
- R3: Each acknowledged access (`dma_ack_i` high) raises the index by one. A burst holds `cfg_len_i` + 1 transfers. Length codes above 17 are stored as 17, which gives 18 transfers.
- R4: `dma_req_o` stays high until the last transfer of the burst is acknowledged and is low in the following cycle. The index is then back at 0.
- R5: Every new request restarts at the base slot. With a base of 14 and a length code of 2, six buffered items go to slots 14, 15 and 16 on the first request and again on the second.
- R6: A write access forwards the 16-bit `dma_wdata_i` on `reg_wdata_o` with `reg_we_o` high. `reg_we_o` is never high without an acknowledged write.
- R7: Slots 19 and 20 are reserved. A write to them is acknowledged, advances the index and keeps `reg_we_o` low. A read from them returns 0.
- R8: `cnt_run_o` is 0 exactly when `dbg_halt_i` and `dbg_freeze_i` are both 1, and is 1 otherwise.
- R9: A write to the configuration register (`cfg_we_i`) sets the index to 0. It leaves the request state as it is.
- R10: A read access (`dma_we_i` = 0) returns `reg_rdata_i` of the indexed slot on `dma_rdata_o` and advances the index in the same way as a write.
- R11: An update that arrives while a burst is active, before its last transfer, is ignored. An update in the same cycle as the acknowledged last transfer re-arms the request, and the next access goes to the base slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_base_i | input | 5 | Base register slot |
| cfg_len_i | input | 5 | Transfers per burst minus one |
| upd_dma_en_i | input | 1 | Enables a DMA request on update |
| update_i | input | 1 | Timer update event pulse |
| dbg_halt_i | input | 1 | Processor halted by debugger |
| dbg_freeze_i | input | 1 | Freeze the counter while halted |
| cnt_run_o | output | 1 | Counter run enable |
| dma_req_o | output | 1 | DMA service request |
| dma_ack_i | input | 1 | DMA access on the window this cycle |
| dma_we_i | input | 1 | Access is a write |
| dma_wdata_i | input | 16 | Write data from DMA |
| dma_rdata_o | output | 16 | Read data to DMA |
| reg_addr_o | output | 8 | Redirected register byte address |
| reg_we_o | output | 1 | Register file write enable |
| reg_wdata_o | output | 16 | Register file write data |
| reg_rdata_i | input | 16 | Register file read data |

## Verification
An update event and the acknowledgement of a burst's last transfer can fall in the same cycle. At that point the request clear and the request set compete, and the index wrap and the index restart compete. The bench drives `update_i` high during that final acknowledgement. It expects the request to remain high and the next access address to be the base slot. It also drives an update during an earlier acknowledgement and expects the index to keep climbing.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned DEF_BASE_W   = 5;
  localparam int unsigned DEF_LEN_W    = 5;
  localparam int unsigned DEF_MAX_XFER = 18;
  localparam int unsigned DEF_DATA_W   = 16;

  typedef enum logic {
    REQ_IDLE = 1'b0,
    REQ_BUSY = 1'b1
  } req_state_e;
endpackage

// File: rtl/burst_cfg.sv
module burst_cfg #(
  parameter int unsigned BASE_W   = 5,
  parameter int unsigned LEN_W    = 5,
  parameter int unsigned MAX_XFER = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [BASE_W-1:0] base_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_XFER - 1);

  logic [BASE_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      len_q  <= '0;
    end else if (we_i) begin
      base_q <= base_i;
      len_q  <= (len_i > LEN_CAP) ? LEN_CAP : len_i;
    end
  end

  assign base_o = base_q;
  assign len_o  = len_q;
endmodule

// File: rtl/burst_index.sv
module burst_index #(
  parameter int unsigned LEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] idx_o,
  output logic             last_o
);
  logic [LEN_W-1:0] idx_q;

  assign last_o = (idx_q == len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (step_i) idx_q <= last_o ? '0 : idx_q + 1'b1;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/burst_req.sv
module burst_req
  import burst_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic update_i,
  input  logic enable_i,
  input  logic ack_i,
  input  logic last_i,
  output logic req_o,
  output logic start_o
);
  req_state_e state_q, state_d;
  logic busy, done;

  assign busy    = (state_q == REQ_BUSY);
  assign done    = busy & ack_i & last_i;
  // a new update is taken when idle or when the burst is closing this cycle
  assign start_o = update_i & enable_i & (~busy | done);

  always_comb begin
    state_d = state_q;
    if (start_o)   state_d = REQ_BUSY;
    else if (done) state_d = REQ_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= REQ_IDLE;
    else         state_q <= state_d;
  end

  assign req_o = busy;
endmodule

// File: rtl/burst_remap.sv
module burst_remap #(
  parameter int unsigned BASE_W = 5,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NSLOT  = 64,
  parameter logic [NSLOT-1:0] RSVD_MASK = '0
) (
  input  logic [BASE_W-1:0]   base_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                acc_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W-1:0]   reg_rdata_i,
  output logic [BASE_W+2:0]   reg_addr_o,
  output logic                reg_we_o,
  output logic [DATA_W-1:0]   reg_wdata_o,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int unsigned SLOT_W = BASE_W + 1;

  logic [SLOT_W-1:0] slot;
  logic [NSLOT-1:0]  slot_hit;
  logic              rsvd;

  assign slot = SLOT_W'(base_i) + SLOT_W'(idx_i);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign slot_hit[g] = (slot == SLOT_W'(g)) & RSVD_MASK[g];
  end

  assign rsvd        = |slot_hit;
  assign reg_addr_o  = {slot, 2'b00};
  assign reg_we_o    = acc_i & we_i & ~rsvd;
  assign reg_wdata_o = wdata_i;
  assign rdata_o     = rsvd ? '0 : reg_rdata_i;
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned BASE_W   = DEF_BASE_W,
  parameter int unsigned LEN_W    = DEF_LEN_W,
  parameter int unsigned MAX_XFER = DEF_MAX_XFER,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter logic [(2**(BASE_W+1))-1:0] RSVD_MASK = 64'h0000_0000_0018_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [BASE_W-1:0] cfg_base_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic              upd_dma_en_i,
  input  logic              update_i,
  input  logic              dbg_halt_i,
  input  logic              dbg_freeze_i,
  output logic              cnt_run_o,
  output logic              dma_req_o,
  input  logic              dma_ack_i,
  input  logic              dma_we_i,
  input  logic [DATA_W-1:0] dma_wdata_i,
  output logic [DATA_W-1:0] dma_rdata_o,
  output logic [BASE_W+2:0] reg_addr_o,
  output logic              reg_we_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int unsigned NSLOT = 2 ** (BASE_W + 1);

  logic [BASE_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  idx_q;
  logic              last;
  logic              start;

  burst_cfg #(.BASE_W(BASE_W), .LEN_W(LEN_W), .MAX_XFER(MAX_XFER)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .base_i (cfg_base_i),
    .len_i  (cfg_len_i),
    .base_o (base_q),
    .len_o  (len_q)
  );

  burst_req u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .update_i (update_i),
    .enable_i (upd_dma_en_i),
    .ack_i    (dma_ack_i),
    .last_i   (last),
    .req_o    (dma_req_o),
    .start_o  (start)
  );

  burst_index #(.LEN_W(LEN_W)) u_idx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cfg_we_i | start),
    .step_i (dma_ack_i),
    .len_i  (len_q),
    .idx_o  (idx_q),
    .last_o (last)
  );

  burst_remap #(
    .BASE_W(BASE_W), .IDX_W(LEN_W), .DATA_W(DATA_W),
    .NSLOT(NSLOT), .RSVD_MASK(RSVD_MASK)
  ) u_map (
    .base_i      (base_q),
    .idx_i       (idx_q),
    .acc_i       (dma_ack_i),
    .we_i        (dma_we_i),
    .wdata_i     (dma_wdata_i),
    .reg_rdata_i (reg_rdata_i),
    .reg_addr_o  (reg_addr_o),
    .reg_we_o    (reg_we_o),
    .reg_wdata_o (reg_wdata_o),
    .rdata_o     (dma_rdata_o)
  );

  assign cnt_run_o = ~(dbg_halt_i & dbg_freeze_i);
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int unsigned LEN_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             upd_i,
  input logic             en_i,
  input logic             ack_i,
  input logic             dma_we_i,
  input logic             req_i,
  input logic             reg_we_i,
  input logic [LEN_W-1:0] idx_i,
  input logic [LEN_W-1:0] len_i
);
  // R1
  req_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && !(upd_i && en_i)) |=> !req_i);

  // R1
  req_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && upd_i && en_i) |=> req_i);

  // R4
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ack_i && idx_i == len_i && !(upd_i && en_i)) |=> (!req_i && idx_i == '0));

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !(ack_i && idx_i == len_i)) |=> req_i);

  // R3
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !cfg_we_i && !(upd_i && en_i && !req_i) && idx_i != len_i)
      |=> idx_i == $past(idx_i) + 1'b1);

  // R3
  idx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_i <= len_i);

  // R9
  cfg_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> idx_i == '0);

  // R6
  reg_we_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |-> (ack_i && dma_we_i));
endmodule

bind burst_seq burst_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_we_i (cfg_we_i),
  .upd_i    (update_i),
  .en_i     (upd_dma_en_i),
  .ack_i    (dma_ack_i),
  .dma_we_i (dma_we_i),
  .req_i    (dma_req_o),
  .reg_we_i (reg_we_o),
  .idx_i    (idx_q),
  .len_i    (len_q)
);

// File: tb/burst_seq_bench.sv
module burst_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_base = '0;
  logic [4:0]  cfg_len = '0;
  logic        ude = 1'b0;
  logic        update = 1'b0;
  logic        halt = 1'b0;
  logic        freeze = 1'b0;
  logic        cnt_run;
  logic        req;
  logic        ack = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  raddr;
  logic        rwe;
  logic [15:0] rwdat;
  logic [15:0] rrdat;

  logic [15:0] mem [64];
  int          exp_mem [64];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [15:0] rd_cap;

  always #4 clk = ~clk;

  burst_seq u_burst_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_base_i(cfg_base),
    .cfg_len_i(cfg_len), .upd_dma_en_i(ude), .update_i(update),
    .dbg_halt_i(halt), .dbg_freeze_i(freeze), .cnt_run_o(cnt_run),
    .dma_req_o(req), .dma_ack_i(ack), .dma_we_i(we), .dma_wdata_i(wdata),
    .dma_rdata_o(rdata), .reg_addr_o(raddr), .reg_we_o(rwe),
    .reg_wdata_o(rwdat), .reg_rdata_i(rrdat)
  );

  // register file model, preloaded with a pattern
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 64; k++) mem[k] <= 16'hA000 + 16'(k);
    end else if (rwe) begin
      mem[raddr[7:2]] <= rwdat;
    end
  end
  assign rrdat = mem[raddr[7:2]];

  // fields: base[10:6] len[5:1] enable[0]
  localparam logic [10:0] VEC [6] = '{
    {5'd14, 5'd2,  1'b1},
    {5'd0,  5'd0,  1'b1},
    {5'd3,  5'd5,  1'b1},
    {5'd30, 5'd31, 1'b1},
    {5'd18, 5'd3,  1'b1},
    {5'd5,  5'd1,  1'b0}
  };

  function automatic bit is_rsvd(int s);
    return (s == 19) || (s == 20);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(logic [4:0] b, logic [4:0] l);
    @(negedge clk);
    cfg_we = 1'b1; cfg_base = b; cfg_len = l;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic pulse_upd();
    @(negedge clk);
    update = 1'b1;
    @(posedge clk); #1;
    update = 1'b0;
  endtask

  task automatic xfer(bit w, logic [15:0] d, bit upd, int slot, string tag);
    @(negedge clk);
    ack = 1'b1; we = w; wdata = d; update = upd;
    #1;
    chk(raddr == 8'(slot * 4), {tag, " R2 addr"}, raddr, slot * 4);
    chk(rwe == (w && !is_rsvd(slot)), {tag, " R6/R7 reg_we"}, rwe, int'(w && !is_rsvd(slot)));
    if (w && !is_rsvd(slot)) chk(rwdat == d, {tag, " R6 wdata"}, rwdat, d);
    rd_cap = rdata;
    @(posedge clk); #1;
    if (w && !is_rsvd(slot)) exp_mem[slot] = d;
    ack = 1'b0; we = 1'b0; update = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 64; k++) exp_mem[k] = 'hA000 + k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // reset state
    chk(req == 1'b0, "R1 reset req", req, 0);
    chk(raddr == 8'd0, "R2 reset addr", raddr, 0);
    chk(cnt_run == 1'b1, "R8 reset run", cnt_run, 1);

    // R8 freeze combinations
    for (int c = 0; c < 4; c++) begin
      halt = c[0]; freeze = c[1];
      #1;
      chk(cnt_run == !(c == 3), "R8 run enable", cnt_run, int'(!(c == 3)));
    end
    halt = 1'b0; freeze = 1'b0;

    // vector walk: R1 R3 R4 R5 R7 R10
    for (int v = 0; v < 6; v++) begin
      int b, n;
      b = int'(VEC[v][10:6]);
      n = (int'(VEC[v][5:1]) > 17 ? 17 : int'(VEC[v][5:1])) + 1;
      ude = VEC[v][0];
      cfg_wr(VEC[v][10:6], VEC[v][5:1]);
      if (!ude) begin
        pulse_upd();
        chk(req == 1'b0, "R1 no request when disabled", req, 0);
        repeat (2) @(posedge clk);
        #1;
        chk(req == 1'b0, "R1 request stays low", req, 0);
        continue;
      end
      for (int r = 0; r < 2; r++) begin
        pulse_upd();
        chk(req == 1'b1, "R1 request raised", req, 1);
        for (int i = 0; i < n; i++) begin
          xfer(1'b1, 16'(v * 256 + r * 64 + i + 1), 1'b0, b + i, "R5/R3 burst");
          chk(req == (i != n - 1), "R4 request until last", req, int'(i != n - 1));
        end
      end
      // read back without a request: R10 and R7
      for (int i = 0; i < n; i++) begin
        int exp_rd;
        exp_rd = is_rsvd(b + i) ? 0 : exp_mem[b + i];
        xfer(1'b0, 16'h0, 1'b0, b + i, "R10 read");
        chk(int'(rd_cap) == exp_rd, "R10/R7 read data", rd_cap, exp_rd);
      end
    end
    // reserved slots untouched in the model
    chk(mem[19] == 16'hA013, "R7 slot 19 untouched", mem[19], 'hA013);
    chk(mem[20] == 16'hA014, "R7 slot 20 untouched", mem[20], 'hA014);

    // R9: configuration write restarts the index
    ude = 1'b1;
    cfg_wr(5'd2, 5'd4);
    pulse_upd();
    xfer(1'b1, 16'h1111, 1'b0, 2, "R9 pre");
    xfer(1'b1, 16'h2222, 1'b0, 3, "R9 pre");
    cfg_wr(5'd2, 5'd4);
    chk(req == 1'b1, "R9 request kept", req, 1);
    for (int i = 0; i < 5; i++) xfer(1'b1, 16'(16'h3000 + i), 1'b0, 2 + i, "R9 restart");
    chk(req == 1'b0, "R9 burst done", req, 0);

    // R11: update mid-burst ignored, update on last transfer re-arms
    cfg_wr(5'd10, 5'd2);
    pulse_upd();
    xfer(1'b1, 16'h4000, 1'b1, 10, "R11 mid");
    chk(req == 1'b1, "R11 request after mid update", req, 1);
    xfer(1'b1, 16'h4001, 1'b0, 11, "R11 mid ignored");
    xfer(1'b1, 16'h4002, 1'b1, 12, "R11 last");
    chk(req == 1'b1, "R11 re-armed", req, 1);
    xfer(1'b1, 16'h4003, 1'b0, 10, "R11 restart base");
    xfer(1'b1, 16'h4004, 1'b0, 11, "R11 second");
    xfer(1'b1, 16'h4005, 1'b0, 12, "R11 second");
    chk(req == 1'b0, "R11 second burst done", req, 0);
    chk(mem[10] == 16'h4003, "R11 slot 10 data", mem[10], 'h4003);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule